// File: doc/BRIEF.md
# KCS Host Messaging Channel with Attention Interrupt

This block is the host-facing end of a keyboard-controller-style messaging channel. It sits on a plain decoded I/O bus that has separate read and write strobes, and it claims a two-byte window. The low byte of the window is the data port. The byte above it is the command/status port. A host write to either port places the byte in an inbound register and raises the input-full flag. The firmware side drains the inbound register through a simple register port and fills the outbound register the same way. The host collects the outbound byte by reading the data port.

The block also keeps an attention bit in the status byte. Three pending conditions feed it: the receive queue holds a message, an event is buffered, or the watchdog pre-timeout has fired. Once set, the bit stays up while outbound messages are still waiting to be flushed. It drops only after every condition is false and that backlog is empty. A level interrupt to the host follows the attention bit whenever the global interrupt enable allows it.

A small command tracker reports the interface state in the status byte. It returns to idle on the get-status/abort command. It also checks the logical unit carried in the first request byte, because the channel serves only unit 0.

Top module: `kcs_host_chan`

## Requirements
- R1: The data port is at the base address and the command/status port is at base+1. The base is 0x0CA2 when `cfg_alt_base` is 0 and `cfg_base` when it is 1. An access to any other address changes no state, and a read of any other address returns 0x00.
- R2: A host write to either port loads the inbound byte and sets input-full (status bit 1) from the next cycle. It also sets the command flag (status bit 3) to 1 for a command-port write and to 0 for a data-port write.
- R3: A firmware read strobe (`ctl_rd`) clears input-full from the next cycle. If a host write happens in the same cycle, the host write wins.
- R4: A firmware write (`ctl_wr`) loads the outbound byte and sets output-full (status bit 0) from the next cycle. A host read of the data port returns the outbound byte in the same cycle and clears output-full from the next cycle. If a firmware write happens in the same cycle, the firmware write wins.
- R5: The attention bit (status bit 2) is 1 in the cycle after any of `rxq_nonempty`, `evt_pending` or `wdt_pretimeout` is 1.
- R6: When all three conditions are 0, attention keeps its previous value while `outq_pending` is 1. It becomes 0 in the cycle after the three conditions and `outq_pending` are all 0.
- R7: `host_irq` equals attention AND `glb_irq_en` at all times.
- R8: Interface state (status bits 7:6, with idle=0, read=1, write=2, error=3) is set by a command-port write from the next cycle. Code 0x60 (get-status/abort) gives idle, 0x61 gives write, 0x62 gives read, and any other code gives error.
- R9: The first data-port byte written after command 0x61 sets `lun_reject` to 1 if its bits 1:0 are nonzero and to 0 otherwise. Later data bytes leave it unchanged. Commands 0x60 and 0x61 clear it.
- R10: After reset the status byte is 0x00, `host_irq` is 0 and `lun_reject` is 0. Status bits 5:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alt_base | input | 1 | Select `cfg_base` instead of the default window base |
| cfg_base | input | 16 | Alternative window base address |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| ctl_rd | input | 1 | Firmware acknowledges the inbound byte |
| ctl_wr | input | 1 | Firmware writes the outbound byte |
| ctl_wdata | input | 8 | Outbound byte from firmware |
| ctl_in_data | output | 8 | Inbound byte for firmware |
| ctl_status | output | 8 | Status byte as the host sees it |
| rxq_nonempty | input | 1 | Receive message queue holds a message |
| evt_pending | input | 1 | Event message buffer is occupied |
| wdt_pretimeout | input | 1 | Watchdog pre-timeout flag |
| outq_pending | input | 1 | Outbound messages are still waiting to be flushed |
| glb_irq_en | input | 1 | Global interrupt enable for attention |
| host_irq | output | 1 | Level interrupt to the host |
| lun_reject | output | 1 | Current request addressed a unit other than 0 |

## Verification
Every register-backed result (input-full, output-full, the command flag, attention, interface state and `lun_reject`) is due one clock edge after the strobe or condition that causes it. Read data and `host_irq` are combinational and are due in the same cycle as the strobe or enable. The bench applies inputs just after a falling edge and compares every output against its reference model 1 ns later, before the next rising edge. The model updates only at that rising edge. This way a same-cycle result and a next-cycle result are each checked in exactly the cycle they are due.

// File: rtl/kcs_host_pkg.sv
package kcs_host_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_ERROR = 2'd3
    } kcs_state_e;

    localparam logic [BYTE_W-1:0] CMD_ABORT    = 8'h60;
    localparam logic [BYTE_W-1:0] CMD_WR_START = 8'h61;
    localparam logic [BYTE_W-1:0] CMD_WR_END   = 8'h62;

    function automatic logic [BYTE_W-1:0] pack_status(
        input kcs_state_e st,
        input logic       cd,
        input logic       atn,
        input logic       ibf,
        input logic       obf
    );
        return {st, 2'b00, cd, atn, ibf, obf};
    endfunction

endpackage

// File: rtl/kcs_addr_dec.sv
module kcs_addr_dec #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DEF_BASE = 16'h0CA2
) (
    input  logic              alt_sel,
    input  logic [ADDR_W-1:0] alt_base,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              data_wr,
    output logic              cmd_wr,
    output logic              data_rd,
    output logic              cmd_rd
);
    localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(1);

    logic [ADDR_W-1:0] base;
    logic              hit_data;
    logic              hit_cmd;

    always_comb begin
        base     = alt_sel ? alt_base : DEF_BASE;
        hit_data = (addr == base);
        hit_cmd  = (addr == base + CMD_OFS);
        data_wr  = wr & hit_data;
        cmd_wr   = wr & hit_cmd;
        data_rd  = rd & hit_data;
        cmd_rd   = rd & hit_cmd;
    end
endmodule

// File: rtl/kcs_buf_regs.sv
module kcs_buf_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_data_wr,
    input  logic          host_cmd_wr,
    input  logic          host_data_rd,
    input  logic [DW-1:0] host_wdata,
    input  logic          ctl_rd,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_wdata,
    output logic [DW-1:0] in_byte,
    output logic [DW-1:0] out_byte,
    output logic          ibf,
    output logic          obf,
    output logic          cd
);
    typedef struct packed {
        logic          ibf;
        logic          obf;
        logic          cd;
        logic [DW-1:0] idr;
        logic [DW-1:0] odr;
    } buf_t;

    buf_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (ctl_rd) begin
            reg_d.ibf = 1'b0;
        end
        if (host_data_wr || host_cmd_wr) begin
            reg_d.ibf = 1'b1;
            reg_d.idr = host_wdata;
            reg_d.cd  = host_cmd_wr;
        end
        if (host_data_rd) begin
            reg_d.obf = 1'b0;
        end
        if (ctl_wr) begin
            reg_d.obf = 1'b1;
            reg_d.odr = ctl_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign in_byte  = reg_q.idr;
    assign out_byte = reg_q.odr;
    assign ibf      = reg_q.ibf;
    assign obf      = reg_q.obf;
    assign cd       = reg_q.cd;

    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_wr || host_cmd_wr) |=> (ibf && in_byte == $past(host_wdata)));

    // R3
    ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !host_data_wr && !host_cmd_wr) |=> !ibf);

    // R4
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (obf && out_byte == $past(ctl_wdata)));

    // R4
    obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_rd && !ctl_wr) |=> !obf);
endmodule

// File: rtl/kcs_atn.sv
module kcs_atn (
    input  logic clk,
    input  logic rst_n,
    input  logic rxq_nonempty,
    input  logic evt_pending,
    input  logic wdt_pretimeout,
    input  logic outq_pending,
    input  logic glb_irq_en,
    output logic atn,
    output logic irq
);
    logic any_cond;
    logic atn_d, atn_q;

    always_comb begin
        any_cond = rxq_nonempty | evt_pending | wdt_pretimeout;
        atn_d    = any_cond | (atn_q & outq_pending);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atn_q <= 1'b0;
        end else begin
            atn_q <= atn_d;
        end
    end

    assign atn = atn_q;
    assign irq = atn_q & glb_irq_en;

    // R5
    atn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_nonempty || evt_pending || wdt_pretimeout) |=> atn);

    // R6
    atn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (atn && outq_pending) |=> atn);

    // R6
    atn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxq_nonempty && !evt_pending && !wdt_pretimeout && !outq_pending) |=> !atn);
endmodule

// File: rtl/kcs_cmd_track.sv
module kcs_cmd_track
    import kcs_host_pkg::*;
#(
    parameter int LUN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output kcs_state_e        state,
    output logic              lun_bad
);
    typedef struct packed {
        kcs_state_e st;
        logic       expect_lun;
        logic       lun_bad;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (cmd_wr) begin
            trk_d.expect_lun = 1'b0;
            case (wdata)
                CMD_ABORT: begin
                    trk_d.st      = ST_IDLE;
                    trk_d.lun_bad = 1'b0;
                end
                CMD_WR_START: begin
                    trk_d.st         = ST_WRITE;
                    trk_d.lun_bad    = 1'b0;
                    trk_d.expect_lun = 1'b1;
                end
                CMD_WR_END: begin
                    trk_d.st = ST_READ;
                end
                default: begin
                    trk_d.st = ST_ERROR;
                end
            endcase
        end else if (data_wr && trk_q.expect_lun) begin
            trk_d.lun_bad    = (wdata[LUN_W-1:0] != '0);
            trk_d.expect_lun = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{st: ST_IDLE, expect_lun: 1'b0, lun_bad: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign state   = trk_q.st;
    assign lun_bad = trk_q.lun_bad;

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata == CMD_ABORT) |=> (state == ST_IDLE && !lun_bad));

    // R8
    start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata == CMD_WR_START) |=> (state == ST_WRITE));

    // R9
    lun_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !data_wr) |=> $stable(lun_bad));
endmodule

// File: rtl/kcs_host_chan.sv
module kcs_host_chan
    import kcs_host_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DEF_BASE = 16'h0CA2,
    parameter int                LUN_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_alt_base,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              ctl_rd,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    output logic [BYTE_W-1:0] ctl_in_data,
    output logic [BYTE_W-1:0] ctl_status,
    input  logic              rxq_nonempty,
    input  logic              evt_pending,
    input  logic              wdt_pretimeout,
    input  logic              outq_pending,
    input  logic              glb_irq_en,
    output logic              host_irq,
    output logic              lun_reject
);
    logic              dec_data_wr, dec_cmd_wr, dec_data_rd, dec_cmd_rd;
    logic [BYTE_W-1:0] out_byte;
    logic              ibf, obf, cd, atn;
    kcs_state_e        state;
    logic [BYTE_W-1:0] status;

    kcs_addr_dec #(.ADDR_W(ADDR_W), .DEF_BASE(DEF_BASE)) u_dec (
        .alt_sel (cfg_alt_base),
        .alt_base(cfg_base),
        .addr    (io_addr),
        .wr      (io_wr),
        .rd      (io_rd),
        .data_wr (dec_data_wr),
        .cmd_wr  (dec_cmd_wr),
        .data_rd (dec_data_rd),
        .cmd_rd  (dec_cmd_rd)
    );

    kcs_buf_regs #(.DW(BYTE_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data_wr(dec_data_wr),
        .host_cmd_wr (dec_cmd_wr),
        .host_data_rd(dec_data_rd),
        .host_wdata  (io_wdata),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .in_byte     (ctl_in_data),
        .out_byte    (out_byte),
        .ibf         (ibf),
        .obf         (obf),
        .cd          (cd)
    );

    kcs_atn u_atn (
        .clk           (clk),
        .rst_n         (rst_n),
        .rxq_nonempty  (rxq_nonempty),
        .evt_pending   (evt_pending),
        .wdt_pretimeout(wdt_pretimeout),
        .outq_pending  (outq_pending),
        .glb_irq_en    (glb_irq_en),
        .atn           (atn),
        .irq           (host_irq)
    );

    kcs_cmd_track #(.LUN_W(LUN_W)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (dec_cmd_wr),
        .data_wr(dec_data_wr),
        .wdata  (io_wdata),
        .state  (state),
        .lun_bad(lun_reject)
    );

    always_comb begin
        status = pack_status(state, cd, atn, ibf, obf);
        if (dec_data_rd) begin
            io_rdata = out_byte;
        end else if (dec_cmd_rd) begin
            io_rdata = status;
        end else begin
            io_rdata = '0;
        end
    end

    assign ctl_status = status;

    // R10
    status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_status[5:4] == 2'b00);

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (ctl_status[2] && glb_irq_en));
endmodule

// File: tb/kcs_host_chan_test.sv
module kcs_host_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_alt_base = 1'b0;
    logic [15:0] cfg_base = 16'h0300;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        ctl_rd = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h0;
    logic [7:0]  ctl_in_data;
    logic [7:0]  ctl_status;
    logic        rxq_nonempty = 1'b0;
    logic        evt_pending = 1'b0;
    logic        wdt_pretimeout = 1'b0;
    logic        outq_pending = 1'b0;
    logic        glb_irq_en = 1'b0;
    logic        host_irq;
    logic        lun_reject;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit       m_ibf, m_obf, m_cd, m_atn, m_lun, m_expect;
    int       m_st;
    bit [7:0] m_idr, m_odr;

    always #4 clk = ~clk;

    kcs_host_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_alt_base(cfg_alt_base), .cfg_base(cfg_base),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_in_data(ctl_in_data), .ctl_status(ctl_status), .rxq_nonempty(rxq_nonempty),
        .evt_pending(evt_pending), .wdt_pretimeout(wdt_pretimeout),
        .outq_pending(outq_pending), .glb_irq_en(glb_irq_en), .host_irq(host_irq),
        .lun_reject(lun_reject)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_status();
        return {m_st[1:0], 2'b00, m_cd, m_atn, m_ibf, m_obf};
    endfunction

    function automatic bit [15:0] m_base();
        return cfg_alt_base ? cfg_base : 16'h0CA2;
    endfunction

    function automatic void model_reset();
        m_ibf = 0; m_obf = 0; m_cd = 0; m_atn = 0; m_lun = 0; m_expect = 0;
        m_st = 0; m_idr = 0; m_odr = 0;
    endfunction

    // compare outputs against the model, then advance one clock
    task automatic step(input string req);
        bit [7:0] exp_rd;
        bit       hit_d, hit_c;
        #1;
        hit_d = (io_addr == m_base());
        hit_c = (io_addr == m_base() + 16'd1);
        exp_rd = 8'h00;
        if (io_rd && hit_d) exp_rd = m_odr;
        else if (io_rd && hit_c) exp_rd = m_status();
        check(req, "io_rdata", io_rdata, exp_rd);
        check(req, "status", ctl_status, m_status());
        check("R7", "host_irq", host_irq, m_atn && glb_irq_en);
        check("R9", "lun_reject", lun_reject, m_lun);
        check("R2", "ctl_in_data", ctl_in_data, m_idr);
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            if (ctl_rd) m_ibf = 0;
            if (io_wr && (hit_d || hit_c)) begin
                m_ibf = 1; m_idr = io_wdata; m_cd = hit_c;
            end
            if (io_rd && hit_d) m_obf = 0;
            if (ctl_wr) begin m_obf = 1; m_odr = ctl_wdata; end
            m_atn = rxq_nonempty || evt_pending || wdt_pretimeout || (m_atn && outq_pending);
            if (io_wr && hit_c) begin
                m_expect = 0;
                if (io_wdata == 8'h60) begin m_st = 0; m_lun = 0; end
                else if (io_wdata == 8'h61) begin m_st = 2; m_lun = 0; m_expect = 1; end
                else if (io_wdata == 8'h62) m_st = 1;
                else m_st = 3;
            end else if (io_wr && hit_d && m_expect) begin
                m_lun = (io_wdata[1:0] != 2'b00);
                m_expect = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        io_wr = 0; io_rd = 0; ctl_rd = 0; ctl_wr = 0;
    endtask

    task automatic host_wr(input bit [15:0] a, input bit [7:0] d, input string req);
        io_addr = a; io_wdata = d; io_wr = 1; step(req); idle_in();
    endtask

    task automatic host_rd(input bit [15:0] a, input string req);
        io_addr = a; io_rd = 1; step(req); idle_in();
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) step("R10");
        rst_n = 1;
        // R10 reset state
        #1;
        check("R10", "status after reset", ctl_status, 8'h00);
        check("R10", "irq after reset", host_irq, 0);
        check("R10", "lun after reset", lun_reject, 0);
        step("R10");

        // R2 data and command writes, R3 firmware drain
        host_wr(16'h0CA2, 8'hA5, "R2");
        step("R2");
        ctl_rd = 1; step("R3"); idle_in();
        host_wr(16'h0CA3, 8'h61, "R2");
        step("R8");
        // R3 write and drain together: write wins
        ctl_rd = 1; io_addr = 16'h0CA2; io_wdata = 8'h20; io_wr = 1; step("R3"); idle_in();
        step("R9");
        // R9 later data byte leaves lun flag unchanged
        host_wr(16'h0CA2, 8'h03, "R9");
        host_wr(16'h0CA3, 8'h61, "R9");
        host_wr(16'h0CA2, 8'h01, "R9");
        host_wr(16'h0CA2, 8'h00, "R9");
        step("R9");
        host_wr(16'h0CA3, 8'h62, "R8");
        host_rd(16'h0CA3, "R8");
        host_wr(16'h0CA3, 8'h77, "R8");
        host_rd(16'h0CA3, "R8");
        host_wr(16'h0CA3, 8'h60, "R8");
        host_rd(16'h0CA3, "R8");

        // R4 outbound path
        ctl_wdata = 8'h5A; ctl_wr = 1; step("R4"); idle_in();
        host_rd(16'h0CA2, "R4");
        step("R4");
        ctl_wdata = 8'h11; ctl_wr = 1; step("R4"); idle_in();
        ctl_wdata = 8'h22; ctl_wr = 1; io_addr = 16'h0CA2; io_rd = 1; step("R4"); idle_in();
        step("R4");

        // R1 other addresses and alternate base
        host_wr(16'h0CA4, 8'hEE, "R1");
        host_rd(16'h0CA1, "R1");
        cfg_alt_base = 1;
        host_wr(16'h0CA2, 8'h99, "R1");
        host_wr(16'h0300, 8'h42, "R1");
        host_rd(16'h0301, "R1");
        host_rd(16'h0300, "R1");
        cfg_alt_base = 0;

        // R5/R6/R7 attention
        glb_irq_en = 1;
        rxq_nonempty = 1; step("R5"); rxq_nonempty = 0;
        step("R6");
        evt_pending = 1; outq_pending = 1; step("R5"); evt_pending = 0;
        repeat (3) step("R6");
        glb_irq_en = 0; step("R7"); glb_irq_en = 1; step("R7");
        outq_pending = 0; step("R6"); step("R6");
        outq_pending = 1; step("R6"); step("R6");
        wdt_pretimeout = 1; step("R5"); wdt_pretimeout = 0; outq_pending = 0;
        step("R6"); step("R6");

        // mixed stimulus
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = $urandom_range(0, 3);
            io_addr = (sel == 0) ? 16'h0CA2 : (sel == 1) ? 16'h0CA3 : (sel == 2) ? 16'h0CA2 : 16'h0500;
            io_wdata = ($urandom_range(0, 1) == 1) ? 8'(8'h60 + $urandom_range(0, 3)) : 8'($urandom_range(0, 255));
            io_wr = ($urandom_range(0, 3) == 0);
            io_rd = !io_wr && ($urandom_range(0, 2) == 0);
            ctl_rd = ($urandom_range(0, 3) == 0);
            ctl_wr = ($urandom_range(0, 4) == 0);
            ctl_wdata = 8'($urandom_range(0, 255));
            rxq_nonempty = ($urandom_range(0, 9) == 0);
            evt_pending = ($urandom_range(0, 11) == 0);
            wdt_pretimeout = ($urandom_range(0, 13) == 0);
            outq_pending = ($urandom_range(0, 2) != 0);
            glb_irq_en = ($urandom_range(0, 3) != 0);
            step("R1");
        end
        idle_in();
        step("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule